// File: doc/BRIEF.md
# Dual-Mode Binary/Decimal 8-bit ALU

This block is the arithmetic and logic unit of a small 8-bit processor datapath. It takes two operands, R and S, and a 3-bit function code. It produces a result byte and a carry flag. The logic functions are exclusive-or, and, or, pass R and pass S. The arithmetic functions are R+S, R plus the inverse of S, and the inverse of R plus S. A single decimal-mode input makes the same arithmetic codes work on packed BCD operands. No separate decimal-adjust pass is needed.

The adder is a chain of 4-bit digit adders. Each digit adder inverts its operands on request. In binary mode an inverted digit is its ones complement. In decimal mode an inverted digit is its nines complement. In decimal mode each digit sum is then corrected into range. The carry-in is either derived from the function code (0 for add, 1 for subtract) or taken from an external carry flag. After a subtract, the carry-out reads 1 when no borrow occurred. The result and carry pass through one output register that has a synchronous active-high reset, so a result appears at the outputs one clock after its inputs.

Top module: `dmalu_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, `y_o` and `cout_o` become 0. Otherwise they take the result of the inputs present at that edge, so they change one clock after the inputs.
- R2: The logic function codes give these results: 000 gives R XOR S, 001 gives R AND S, 010 gives R OR S, 011 passes R and 111 passes S.
- R3: The arithmetic function codes select the adder: 100 computes R+S+cin, 101 computes R+inv(S)+cin and 110 computes inv(R)+S+cin. Function bit 1 inverts R and function bit 0 inverts S. In binary mode (`dec_i`=0), inv is the bitwise complement, the result is the sum modulo 256 and `cout_o` is bit 8 of the sum.
- R4: The carry-in is (func bit 1 OR func bit 0) when `cin_sel_i`=0, and `df_i` when `cin_sel_i`=1.
- R5: The low digit's carry feeds the high digit, and `cout_o` is the high digit's carry. The adder is always evaluated with the inversions set by function bits 1 and 0, so `cout_o` carries that adder carry for every function code, logic codes included.
- R6: In decimal mode (`dec_i`=1), an inverted digit d becomes (9 - d) modulo 16. This is its nines complement for d from 0 to 9.
- R7: In decimal mode, each digit's raw sum t (0 to 31) is corrected. When t > 9 the digit is (t+6) modulo 16 and its carry is 1. Otherwise the digit is t and its carry is 0. For example, 9+9+1 gives digit 9 with carry 1.
- R8: After any subtract, in either mode, `cout_o`=1 means no borrow. For example, 0x05 minus 0x07 in binary gives 0xFE with carry 0, and decimal 10 minus 01 gives 0x09 with carry 1.
- R9: 0x07+0x07 with carry-in 0 gives 0x0E in binary mode and 0x14 in decimal mode, both with carry 0.
- R10: Operand digits above 9 in decimal mode still give a fully defined result under the R6 and R7 rules. For example, 0x00 minus 0x0F with carry-in 1 gives 0x01 with carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| func_i | input | 3 | Function code |
| dec_i | input | 1 | 1 selects packed-BCD arithmetic |
| cin_sel_i | input | 1 | 0: carry-in from function code, 1: carry-in from `df_i` |
| df_i | input | 1 | External carry flag |
| r_i | input | 8 | Operand R |
| s_i | input | 8 | Operand S |
| y_o | output | 8 | Registered result |
| cout_o | output | 1 | Registered adder carry-out |

## Verification
The only state is the output register, so every error surfaces at the ports on the clock edge after the inputs that expose it. A wrong nines complement or a wrong digit correction shows as a wrong result digit. A broken carry between digits shows as a high digit off by one, or as a wrong carry flag. A wrong carry-in selection shows as results that are off by one on the low end. Results are checked for every operand pair in both modes. Valid BCD pairs are also checked against plain decimal arithmetic, so a correction table that is merely self-consistent cannot hide behind a matching model.

// File: rtl/dmalu_pkg.sv
package dmalu_pkg;

  localparam int unsigned DIGIT_W = 4;

  typedef enum logic [2:0] {
    OP_XOR       = 3'b000,
    OP_AND       = 3'b001,
    OP_OR        = 3'b010,
    OP_PASS_R    = 3'b011,
    OP_ADD       = 3'b100,
    OP_R_MINUS_S = 3'b101,
    OP_S_MINUS_R = 3'b110,
    OP_PASS_S    = 3'b111
  } alu_op_e;

  // nines complement, wraps modulo 16 for non-decimal digits
  function automatic logic [DIGIT_W-1:0] nines(input logic [DIGIT_W-1:0] d);
    return 4'd9 - d;
  endfunction

  // decimal digit correction of a raw 5-bit digit sum: {carry, digit}
  function automatic logic [DIGIT_W:0] dec_fix(input logic [DIGIT_W:0] t);
    logic [DIGIT_W:0] adj;
    adj = t + 5'd6;
    if (t > 5'd9) return {1'b1, adj[DIGIT_W-1:0]};
    return {1'b0, t[DIGIT_W-1:0]};
  endfunction

endpackage

// File: rtl/dmalu_digit.sv
module dmalu_digit
  import dmalu_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  input  logic               inv_a_i,
  input  logic               inv_b_i,
  input  logic               dec_i,
  input  logic               cin_i,
  output logic [DIGIT_W-1:0] y_o,
  output logic               cout_o
);

  logic [DIGIT_W-1:0] a_c, b_c;
  logic [DIGIT_W+1:0] ext_sum;
  logic [DIGIT_W:0]   raw, fixed;

  always_comb begin
    a_c = inv_a_i ? (dec_i ? nines(a_i) : ~a_i) : a_i;
    b_c = inv_b_i ? (dec_i ? nines(b_i) : ~b_i) : b_i;
    // carry-in rides in the low guard bit, carry-out lands in the top bit
    ext_sum = {1'b0, a_c, 1'b1} + {1'b0, b_c, cin_i};
    raw     = ext_sum[DIGIT_W+1:1];
    fixed   = dec_fix(raw);
    y_o     = dec_i ? fixed[DIGIT_W-1:0] : raw[DIGIT_W-1:0];
    cout_o  = dec_i ? fixed[DIGIT_W]     : raw[DIGIT_W];
  end

  // R7: valid decimal digits in always give a valid decimal digit out
  always_comb begin
    if (dec_i && (a_i <= 4'd9) && (b_i <= 4'd9)) begin
      a_r7_digit_in_range: assert (y_o <= 4'd9);
    end
  end

endmodule

// File: rtl/dmalu_chain.sv
module dmalu_chain
  import dmalu_pkg::*;
#(
  parameter int unsigned DIGITS = 2
) (
  input  logic [DIGITS*DIGIT_W-1:0] r_i,
  input  logic [DIGITS*DIGIT_W-1:0] s_i,
  input  logic                      inv_r_i,
  input  logic                      inv_s_i,
  input  logic                      dec_i,
  input  logic                      cin_i,
  output logic [DIGITS*DIGIT_W-1:0] sum_o,
  output logic                      cout_o
);

  logic [DIGITS:0] carry;

  assign carry[0] = cin_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    dmalu_digit i_digit (
      .a_i     (r_i[g*DIGIT_W +: DIGIT_W]),
      .b_i     (s_i[g*DIGIT_W +: DIGIT_W]),
      .inv_a_i (inv_r_i),
      .inv_b_i (inv_s_i),
      .dec_i   (dec_i),
      .cin_i   (carry[g]),
      .y_o     (sum_o[g*DIGIT_W +: DIGIT_W]),
      .cout_o  (carry[g+1])
    );
  end

  assign cout_o = carry[DIGITS];

endmodule

// File: rtl/dmalu_select.sv
module dmalu_select
  import dmalu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] r_i,
  input  logic [WIDTH-1:0] s_i,
  input  logic [WIDTH-1:0] sum_i,
  output logic [WIDTH-1:0] y_o
);

  always_comb begin
    unique case (op_i)
      OP_XOR:       y_o = r_i ^ s_i;
      OP_AND:       y_o = r_i & s_i;
      OP_OR:        y_o = r_i | s_i;
      OP_PASS_R:    y_o = r_i;
      OP_PASS_S:    y_o = s_i;
      default:      y_o = sum_i;
    endcase
  end

endmodule

// File: rtl/dmalu_top.sv
module dmalu_top
  import dmalu_pkg::*;
#(
  parameter int unsigned DIGITS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [2:0]                func_i,
  input  logic                      dec_i,
  input  logic                      cin_sel_i,
  input  logic                      df_i,
  input  logic [DIGITS*DIGIT_W-1:0] r_i,
  input  logic [DIGITS*DIGIT_W-1:0] s_i,
  output logic [DIGITS*DIGIT_W-1:0] y_o,
  output logic                      cout_o
);

  localparam int unsigned WIDTH = DIGITS * DIGIT_W;

  alu_op_e          op;
  logic             cin;
  logic [WIDTH-1:0] sum, res;
  logic             add_cout;

  assign op  = alu_op_e'(func_i);
  assign cin = cin_sel_i ? df_i : (func_i[1] | func_i[0]);

  dmalu_chain #(.DIGITS(DIGITS)) i_chain (
    .r_i     (r_i),
    .s_i     (s_i),
    .inv_r_i (func_i[1]),
    .inv_s_i (func_i[0]),
    .dec_i   (dec_i),
    .cin_i   (cin),
    .sum_o   (sum),
    .cout_o  (add_cout)
  );

  dmalu_select #(.WIDTH(WIDTH)) i_select (
    .op_i  (op),
    .r_i   (r_i),
    .s_i   (s_i),
    .sum_i (sum),
    .y_o   (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_o    <= '0;
      cout_o <= 1'b0;
    end else begin
      y_o    <= res;
      cout_o <= add_cout;
    end
  end

  // R2: pass S reaches the output one clock later
  a_r2_pass_s: assert property (@(posedge clk) disable iff (rst)
    (func_i == 3'b111) |=> (y_o == $past(s_i)));

  // R2: and function
  a_r2_and: assert property (@(posedge clk) disable iff (rst)
    (func_i == 3'b001) |=> (y_o == ($past(r_i) & $past(s_i))));

  // R4: zero operands with external carry give the carry flag as result
  a_r4_df_carry: assert property (@(posedge clk) disable iff (rst)
    (func_i == 3'b100 && cin_sel_i && !dec_i && r_i == '0 && s_i == '0)
    |=> (y_o == WIDTH'($past(df_i)) && !cout_o));

  // R8: subtracting equal operands yields zero with no borrow in both modes
  a_r8_self_sub: assert property (@(posedge clk) disable iff (rst)
    (func_i == 3'b101 && !cin_sel_i && r_i == s_i)
    |=> (y_o == '0 && cout_o));

endmodule

// File: tb/test_dmalu_top.sv
module test_dmalu_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] func = '0;
  logic       dec = 1'b0, csel = 1'b0, df = 1'b0;
  logic [7:0] r = '0, s = '0;
  logic [7:0] y;
  logic       cout;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dmalu_top i_dmalu_top (
    .clk(clk), .rst(rst), .func_i(func), .dec_i(dec), .cin_sel_i(csel),
    .df_i(df), .r_i(r), .s_i(s), .y_o(y), .cout_o(cout)
  );

  // reference from R2..R7: returns {carry, result}
  function automatic logic [8:0] model(input logic [2:0] f, input logic d,
      input logic cs, input logic fl, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] sm;
    logic       c;
    c = cs ? fl : (f[1] | f[0]);
    for (int k = 0; k < 2; k++) begin
      logic [3:0] x, z;
      logic [4:0] t;
      x = a[k*4 +: 4];
      z = b[k*4 +: 4];
      if (f[1]) x = d ? 4'(9 - x) : ~x;
      if (f[0]) z = d ? 4'(9 - z) : ~z;
      t = 5'(x) + 5'(z) + 5'(c);
      if (d && t > 9) begin sm[k*4 +: 4] = 4'(t + 6); c = 1'b1; end
      else begin sm[k*4 +: 4] = t[3:0]; c = d ? 1'b0 : t[4]; end
    end
    case (f)
      3'b000:  return {c, a ^ b};
      3'b001:  return {c, a & b};
      3'b010:  return {c, a | b};
      3'b011:  return {c, a};
      3'b111:  return {c, b};
      default: return {c, sm};
    endcase
  endfunction

  function automatic bit is_bcd(input logic [7:0] v);
    return (v[3:0] <= 9) && (v[7:4] <= 9);
  endfunction

  // plain decimal arithmetic for valid BCD operands (R6, R7, R8)
  function automatic logic [8:0] decimal(input logic [2:0] f, input logic cs,
      input logic fl, input logic [7:0] a, input logic [7:0] b);
    int av, bv, t, c;
    av = a[7:4] * 10 + a[3:0];
    bv = b[7:4] * 10 + b[3:0];
    c  = cs ? int'(fl) : int'(f[1] | f[0]);
    if (f[1]) av = 99 - av;
    if (f[0]) bv = 99 - bv;
    t = av + bv + c;
    return {t >= 100 ? 1'b1 : 1'b0, 4'((t % 100) / 10), 4'(t % 10)};
  endfunction

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got cout=%0b y=%02h expected cout=%0b y=%02h",
               tag, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic apply(input logic [2:0] f, input logic d, input logic cs,
      input logic fl, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    func = f; dec = d; csel = cs; df = fl; r = a; s = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h1802;
    void'($urandom(seed));

    // R1: reset clears outputs even with inputs that would give nonzero
    apply(3'b100, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF);
    check("R1 reset", {cout, y}, 9'h000);
    @(negedge clk) rst = 1'b0;

    // R9: 07+07 in both modes
    apply(3'b100, 1'b0, 1'b0, 1'b0, 8'h07, 8'h07);
    check("R9 binary 07+07", {cout, y}, {1'b0, 8'h0E});
    apply(3'b100, 1'b1, 1'b0, 1'b0, 8'h07, 8'h07);
    check("R9 decimal 07+07", {cout, y}, {1'b0, 8'h14});
    // R7: 9+9+1 per digit
    apply(3'b100, 1'b1, 1'b1, 1'b1, 8'h99, 8'h99);
    check("R7 decimal 99+99+1", {cout, y}, {1'b1, 8'h99});
    // R8: borrow convention
    apply(3'b101, 1'b0, 1'b0, 1'b0, 8'h05, 8'h07);
    check("R8 binary 05-07", {cout, y}, {1'b0, 8'hFE});
    apply(3'b101, 1'b1, 1'b0, 1'b0, 8'h10, 8'h01);
    check("R8 decimal 10-01", {cout, y}, {1'b1, 8'h09});
    // R6/R10: out-of-range digit in decimal subtract
    apply(3'b101, 1'b1, 1'b0, 1'b0, 8'h00, 8'h0F);
    check("R10 decimal 00-0F", {cout, y}, {1'b1, 8'h01});
    // R4: carry-in selection
    apply(3'b100, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
    check("R4 df carry-in", {cout, y}, {1'b0, 8'h01});
    apply(3'b100, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    check("R4 fixed add carry-in", {cout, y}, {1'b0, 8'h00});
    apply(3'b110, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    check("R4 fixed sub carry-in", {cout, y}, {1'b1, 8'h00});
    // R5: carry ripple across digits
    apply(3'b100, 1'b0, 1'b0, 1'b0, 8'h0F, 8'h01);
    check("R5 digit ripple", {cout, y}, {1'b0, 8'h10});
    // R2: logic codes, with R5 adder carry alongside
    apply(3'b000, 1'b0, 1'b0, 1'b0, 8'hF0, 8'h3C);
    check("R2 xor", {cout, y}, model(3'b000, 1'b0, 1'b0, 1'b0, 8'hF0, 8'h3C));
    apply(3'b010, 1'b0, 1'b0, 1'b0, 8'hA0, 8'h05);
    check("R2 or", {cout, y}, {1'b0, 8'hA5});

    // R3/R5/R6/R7/R10: every operand pair in both modes, function swept
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          logic [2:0] f;
          logic       cs, fl;
          f  = 3'(a + b + m);
          cs = a[1] ^ b[0];
          fl = b[2] ^ a[5];
          apply(f, m[0], cs, fl, 8'(a), 8'(b));
          check("R3 exhaustive", {cout, y}, model(f, m[0], cs, fl, 8'(a), 8'(b)));
          if (m == 1 && f[2] && f != 3'b111 && is_bcd(8'(a)) && is_bcd(8'(b)))
            check("R8 decimal arithmetic", {cout, y}, decimal(f, cs, fl, 8'(a), 8'(b)));
        end
      end
    end

    // random mix, reset pulses included (R1)
    for (int i = 0; i < 20000; i++) begin
      logic [2:0] f;
      logic [7:0] a, b;
      logic       d, cs, fl;
      f = 3'($urandom); d = 1'($urandom); cs = 1'($urandom); fl = 1'($urandom);
      a = 8'($urandom); b = 8'($urandom);
      if (i % 997 == 0) begin
        @(negedge clk) rst = 1'b1;
        apply(f, d, cs, fl, a, b);
        check("R1 reset pulse", {cout, y}, 9'h000);
        @(negedge clk) rst = 1'b0;
      end
      apply(f, d, cs, fl, a, b);
      check("R2 random", {cout, y}, model(f, d, cs, fl, a, b));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got hung run expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule